// File: doc/BRIEF.md
# Dual-Vector-Unit Co-Issue Dispatcher

This block sits between a shader instruction decoder and one pixel pipeline that has two four-lane vector units. Each cycle the decoder presents up to four decoded instructions. The dispatcher works through them in program order and decides how many can issue together in that cycle. For each unit it reports which window entries occupy its two issue slots and which component lanes each of them uses. A half-precision normalize has a dedicated pre-ALU position on the first unit and takes no ALU slot.

The two units accept different opcode classes. Unit A takes multiply, texture and complex scalar operations. Unit B takes multiply, add, multiply-add and three-component dot product. Either unit can hold one instruction across all four lanes, or two instructions whose write masks form a 2+2 split or a 3+1 split. Class matching and lane packing are therefore settled together, one entry after another, in a combinational chain. The number of entries consumed goes back to the decoder in the same cycle. The issue slots are registered and reach the units one clock later.

Each unit is tracked through a per-cycle state machine. Every cycle it starts in `U_EMPTY`. It moves from `U_EMPTY` to `U_ONE` when it accepts any non-texture instruction, from `U_EMPTY` to `U_TEX` when it accepts a texture, and from `U_ONE` to `U_PAIR` when a second instruction forms a legal split with the first. `U_PAIR` and `U_TEX` accept nothing further in that cycle.

Top module: `cois_dispatch`

## Requirements
- R1: While reset is asserted (`rst_n` low), `iss_vld`, `ua_vld`, `ub_vld` and `nrm_vld` are all 0.
- R2: `take_vld` equals `win_vld[0]`. When it is high, `take_cnt` is the length (1 to 4) of the prefix of the window that issues. When it is low, `take_cnt` is 0. One clock later, `iss_vld` and `iss_cnt` repeat these values, together with the slot contents of that group.
- R3: Dispatch is strictly in order. The first valid entry that cannot be placed ends the group, and no later entry issues in that cycle, even if it would fit.
- R4: An entry at position 1 or higher whose `win_rdep` bit is set (it reads a result written earlier in the window) ends the group. The `win_rdep` bit of entry 0 is ignored.
- R5: Opcode codes are MUL=0, ADD=1, MAD=2, DP3=3, TEX=4, CPLX=5, NRMH=6. ADD, MAD and DP3 go only to unit B. TEX and CPLX go only to unit A. A MUL goes to unit B if B can take it, otherwise to unit A.
- R6: Write-mask bit 0 is lane x and bit 3 is lane w. A second instruction joins a unit only when the two masks form a 2+2 split (one mask inside {x,y} and the other inside {z,w}) or a 3+1 split (one mask inside {x,y,z} and the other exactly {w}). A unit holds at most two instructions.
- R7: A TEX needs unit A to be empty. It takes slot 0 of unit A with lanes 4'b1111, and unit A then accepts nothing else in that group.
- R8: A CPLX is placed on unit A with lanes exactly 4'b1000 ({w}), whatever its own mask. It fits when unit A is empty or holds one instruction whose mask lies inside {x,y,z}.
- R9: An NRMH uses no unit slot. It is reported on `nrm_vld`/`nrm_idx`. Only one NRMH issues per group, and a second NRMH ends the group.
- R10: For each unit, slot 0 (bits [1:0] of `*_idx`, bits [3:0] of `*_lanes`) holds the earlier instruction in program order and slot 1 the later one. Each slot's index is the entry's window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_vld | input | 4 | Per-entry valid, contiguous from entry 0 |
| win_op | input | 12 | Opcode class, 3 bits per entry, entry i at [3i+2:3i] |
| win_mask | input | 16 | Write mask, 4 bits per entry, entry i at [4i+3:4i] |
| win_rdep | input | 4 | Per-entry flag: reads a result of an earlier window entry |
| take_vld | output | 1 | Consume handshake to the decoder |
| take_cnt | output | 3 | Number of entries consumed this cycle |
| iss_vld | output | 1 | Registered group valid |
| iss_cnt | output | 3 | Registered instruction count of the group |
| ua_vld | output | 2 | Unit A slot valids |
| ua_idx | output | 4 | Unit A slot window indices, 2 bits per slot |
| ua_lanes | output | 8 | Unit A slot lane masks, 4 bits per slot |
| ub_vld | output | 2 | Unit B slot valids |
| ub_idx | output | 4 | Unit B slot window indices |
| ub_lanes | output | 8 | Unit B slot lane masks |
| nrm_vld | output | 1 | Pre-ALU normalize issued |
| nrm_idx | output | 2 | Window index of the normalize |

## Verification
`take_vld` and `take_cnt` are combinational in the window. The bench drives the window on the falling edge and samples these outputs one time unit later, in the same cycle. The issue outputs pass through one register and are due after the next rising edge, so the bench samples them one time unit after that edge. It compares them with the reference result it computed for the window held in the previous half cycle. Because every window is held for exactly one full clock, each comparison refers to a single stimulus.

// File: rtl/cois_pkg.sv
package cois_pkg;
    localparam int OPW   = 3;
    localparam int LANES = 4;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_ADD  = 3'd1,
        OP_MAD  = 3'd2,
        OP_DP3  = 3'd3,
        OP_TEX  = 3'd4,
        OP_CPLX = 3'd5,
        OP_NRMH = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        U_EMPTY,
        U_ONE,
        U_PAIR,
        U_TEX
    } ust_e;

    typedef struct packed {
        ust_e             st;
        logic [LANES-1:0] m;
    } unit_t;

    localparam logic [LANES-1:0] LN_XY  = 4'b0011;
    localparam logic [LANES-1:0] LN_ZW  = 4'b1100;
    localparam logic [LANES-1:0] LN_XYZ = 4'b0111;
    localparam logic [LANES-1:0] LN_W   = 4'b1000;
    localparam logic [LANES-1:0] LN_ALL = 4'b1111;

    function automatic logic inside_set(logic [LANES-1:0] m, logic [LANES-1:0] s);
        return (m & ~s) == '0;
    endfunction

    function automatic logic split_ok(logic [LANES-1:0] p, logic [LANES-1:0] n);
        logic two_two, three_one;
        two_two   = (inside_set(p, LN_XY) && inside_set(n, LN_ZW)) ||
                    (inside_set(p, LN_ZW) && inside_set(n, LN_XY));
        three_one = (inside_set(p, LN_XYZ) && n == LN_W) ||
                    (p == LN_W && inside_set(n, LN_XYZ));
        return two_two || three_one;
    endfunction
endpackage

// File: rtl/cois_lane_fit.sv
module cois_lane_fit
    import cois_pkg::*;
(
    input  unit_t            cur,
    input  logic [LANES-1:0] mask,
    input  logic             want_tex,
    output logic             fit,
    output logic             slot,
    output unit_t            nxt
);
    always_comb begin
        fit  = 1'b0;
        slot = 1'b0;
        nxt  = cur;
        unique case (cur.st)
            U_EMPTY: begin
                fit    = 1'b1;
                nxt.st = want_tex ? U_TEX : U_ONE;
                nxt.m  = want_tex ? LN_ALL : mask;
            end
            U_ONE: begin
                if (!want_tex && split_ok(cur.m, mask)) begin
                    fit    = 1'b1;
                    slot   = 1'b1;
                    nxt.st = U_PAIR;
                    nxt.m  = cur.m | mask;
                end
            end
            U_PAIR, U_TEX: begin
                fit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cois_stage.sv
module cois_stage
    import cois_pkg::*;
#(
    parameter bit FIRST = 1'b0
) (
    input  logic             alive_in,
    input  logic             vld,
    input  logic [OPW-1:0]   op,
    input  logic [LANES-1:0] mask,
    input  logic             rdep,
    input  unit_t            ua_in,
    input  unit_t            ub_in,
    input  logic             nrm_in,
    output logic             placed,
    output logic             to_a,
    output logic             to_b,
    output logic             to_n,
    output logic             slot,
    output logic [LANES-1:0] lanes,
    output unit_t            ua_out,
    output unit_t            ub_out,
    output logic             nrm_out
);
    op_e              opc;
    logic             can_go;
    logic             a_fit, b_fit, a_slot, b_slot;
    logic [LANES-1:0] a_mask;
    unit_t            a_nxt, b_nxt;

    assign opc    = op_e'(op);
    assign can_go = alive_in && vld && (FIRST || !rdep);
    assign a_mask = (opc == OP_CPLX) ? LN_W : mask;

    cois_lane_fit u_fit_a (
        .cur      (ua_in),
        .mask     (a_mask),
        .want_tex (opc == OP_TEX),
        .fit      (a_fit),
        .slot     (a_slot),
        .nxt      (a_nxt)
    );

    cois_lane_fit u_fit_b (
        .cur      (ub_in),
        .mask     (mask),
        .want_tex (1'b0),
        .fit      (b_fit),
        .slot     (b_slot),
        .nxt      (b_nxt)
    );

    always_comb begin
        to_a = 1'b0;
        to_b = 1'b0;
        to_n = 1'b0;
        unique case (opc)
            OP_NRMH:         to_n = can_go && !nrm_in;
            OP_TEX, OP_CPLX: to_a = can_go && a_fit;
            OP_MUL: begin
                to_b = can_go && b_fit;
                to_a = can_go && !b_fit && a_fit;
            end
            default:         to_b = can_go && b_fit;
        endcase
    end

    always_comb begin
        lanes = mask;
        if (to_a) begin
            if (opc == OP_TEX)       lanes = LN_ALL;
            else if (opc == OP_CPLX) lanes = LN_W;
        end
    end

    assign placed  = to_a || to_b || to_n;
    assign slot    = to_a ? a_slot : b_slot;
    assign ua_out  = to_a ? a_nxt : ua_in;
    assign ub_out  = to_b ? b_nxt : ub_in;
    assign nrm_out = nrm_in || to_n;
endmodule

// File: rtl/cois_dispatch.sv
module cois_dispatch
    import cois_pkg::*;
#(
    parameter int WIN = 4,
    localparam int IW = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN-1:0]       win_vld,
    input  logic [WIN*OPW-1:0]   win_op,
    input  logic [WIN*LANES-1:0] win_mask,
    input  logic [WIN-1:0]       win_rdep,
    output logic                 take_vld,
    output logic [CW-1:0]        take_cnt,
    output logic                 iss_vld,
    output logic [CW-1:0]        iss_cnt,
    output logic [1:0]           ua_vld,
    output logic [2*IW-1:0]      ua_idx,
    output logic [2*LANES-1:0]   ua_lanes,
    output logic [1:0]           ub_vld,
    output logic [2*IW-1:0]      ub_idx,
    output logic [2*LANES-1:0]   ub_lanes,
    output logic                 nrm_vld,
    output logic [IW-1:0]        nrm_idx
);
    unit_t            ua_c    [WIN+1];
    unit_t            ub_c    [WIN+1];
    logic             alive_c [WIN+1];
    logic             nrm_c   [WIN+1];
    logic [WIN-1:0]   to_a, to_b, to_n, slot_c;
    logic [LANES-1:0] lanes_c [WIN];

    assign ua_c[0]    = '{st: U_EMPTY, m: '0};
    assign ub_c[0]    = '{st: U_EMPTY, m: '0};
    assign alive_c[0] = 1'b1;
    assign nrm_c[0]   = 1'b0;

    for (genvar g = 0; g < WIN; g++) begin : g_stage
        cois_stage #(.FIRST(g == 0)) u_stg (
            .alive_in (alive_c[g]),
            .vld      (win_vld[g]),
            .op       (win_op[g*OPW +: OPW]),
            .mask     (win_mask[g*LANES +: LANES]),
            .rdep     (win_rdep[g]),
            .ua_in    (ua_c[g]),
            .ub_in    (ub_c[g]),
            .nrm_in   (nrm_c[g]),
            .placed   (alive_c[g+1]),
            .to_a     (to_a[g]),
            .to_b     (to_b[g]),
            .to_n     (to_n[g]),
            .slot     (slot_c[g]),
            .lanes    (lanes_c[g]),
            .ua_out   (ua_c[g+1]),
            .ub_out   (ub_c[g+1]),
            .nrm_out  (nrm_c[g+1])
        );
    end

    logic [1:0]         a_vld_n, b_vld_n;
    logic [2*IW-1:0]    a_idx_n, b_idx_n;
    logic [2*LANES-1:0] a_ln_n, b_ln_n;
    logic               n_vld_n;
    logic [IW-1:0]      n_idx_n;
    logic [CW-1:0]      cnt_n;

    always_comb begin
        a_vld_n = '0; a_idx_n = '0; a_ln_n = '0;
        b_vld_n = '0; b_idx_n = '0; b_ln_n = '0;
        n_vld_n = 1'b0; n_idx_n = '0;
        cnt_n   = '0;
        for (int i = 0; i < WIN; i++) begin
            cnt_n = cnt_n + CW'(alive_c[i+1]);
            if (to_a[i]) begin
                if (slot_c[i]) begin
                    a_vld_n[1] = 1'b1;
                    a_idx_n[IW +: IW] = IW'(i);
                    a_ln_n[LANES +: LANES] = lanes_c[i];
                end else begin
                    a_vld_n[0] = 1'b1;
                    a_idx_n[0 +: IW] = IW'(i);
                    a_ln_n[0 +: LANES] = lanes_c[i];
                end
            end
            if (to_b[i]) begin
                if (slot_c[i]) begin
                    b_vld_n[1] = 1'b1;
                    b_idx_n[IW +: IW] = IW'(i);
                    b_ln_n[LANES +: LANES] = lanes_c[i];
                end else begin
                    b_vld_n[0] = 1'b1;
                    b_idx_n[0 +: IW] = IW'(i);
                    b_ln_n[0 +: LANES] = lanes_c[i];
                end
            end
            if (to_n[i]) begin
                n_vld_n = 1'b1;
                n_idx_n = IW'(i);
            end
        end
    end

    assign take_vld = win_vld[0];
    assign take_cnt = cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld  <= 1'b0;
            iss_cnt  <= '0;
            ua_vld   <= '0;
            ua_idx   <= '0;
            ua_lanes <= '0;
            ub_vld   <= '0;
            ub_idx   <= '0;
            ub_lanes <= '0;
            nrm_vld  <= 1'b0;
            nrm_idx  <= '0;
        end else begin
            iss_vld  <= take_vld;
            iss_cnt  <= take_cnt;
            ua_vld   <= a_vld_n;
            ua_idx   <= a_idx_n;
            ua_lanes <= a_ln_n;
            ub_vld   <= b_vld_n;
            ub_idx   <= b_idx_n;
            ub_lanes <= b_ln_n;
            nrm_vld  <= n_vld_n;
            nrm_idx  <= n_idx_n;
        end
    end

    // R2
    take_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (take_cnt >= CW'(1) && take_cnt <= CW'(WIN)));
    // R2
    take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_vld |-> take_cnt == '0);
    // R2
    iss_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |=> (iss_vld && iss_cnt == $past(take_cnt)));
    // R9
    slot_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> $countones({ua_vld, ub_vld, nrm_vld}) == int'(iss_cnt));
    // R6
    a_lane_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ua_vld == 2'b11 |-> (ua_lanes[0 +: LANES] & ua_lanes[LANES +: LANES]) == '0);
    // R6
    b_lane_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ub_vld == 2'b11 |-> (ub_lanes[0 +: LANES] & ub_lanes[LANES +: LANES]) == '0);
    // R10
    a_slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ua_vld[1] |-> (ua_vld[0] && ua_idx[IW +: IW] > ua_idx[0 +: IW]));
    // R10
    b_slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ub_vld[1] |-> (ub_vld[0] && ub_idx[IW +: IW] > ub_idx[0 +: IW]));
    // R7
    a_full_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ua_vld[0] && ua_lanes[0 +: LANES] == LN_ALL) |-> !ua_vld[1]);
endmodule

// File: tb/cois_dispatch_bench.sv
module cois_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  win_vld = '0;
    logic [11:0] win_op = '0;
    logic [15:0] win_mask = '0;
    logic [3:0]  win_rdep = '0;
    logic        take_vld, iss_vld, nrm_vld;
    logic [2:0]  take_cnt, iss_cnt;
    logic [1:0]  ua_vld, ub_vld, nrm_idx;
    logic [3:0]  ua_idx, ub_idx;
    logic [7:0]  ua_lanes, ub_lanes;

    int nchk = 0;
    int nfail = 0;

    int e_cnt;
    int e_av [2], e_ai [2], e_al [2];
    int e_bv [2], e_bi [2], e_bl [2];
    int e_nv, e_ni;

    always #10 clk = ~clk;

    cois_dispatch u_cois_dispatch (
        .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_op(win_op),
        .win_mask(win_mask), .win_rdep(win_rdep), .take_vld(take_vld),
        .take_cnt(take_cnt), .iss_vld(iss_vld), .iss_cnt(iss_cnt),
        .ua_vld(ua_vld), .ua_idx(ua_idx), .ua_lanes(ua_lanes),
        .ub_vld(ub_vld), .ub_idx(ub_idx), .ub_lanes(ub_lanes),
        .nrm_vld(nrm_vld), .nrm_idx(nrm_idx)
    );

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit pair_fits(int p, int n);
        if ((p & ~3) == 0 && (n & ~12) == 0) return 1;
        if ((p & ~12) == 0 && (n & ~3) == 0) return 1;
        if ((p & ~7) == 0 && n == 8) return 1;
        if (p == 8 && (n & ~7) == 0) return 1;
        return 0;
    endfunction

    // Behavioural reference: walks the window in order with lane bookkeeping.
    task automatic model();
        int an = 0, bn = 0, am = 0, bm = 0;
        bit nused = 0;
        e_cnt = 0; e_nv = 0; e_ni = 0;
        for (int s = 0; s < 2; s++) begin
            e_av[s] = 0; e_ai[s] = 0; e_al[s] = 0;
            e_bv[s] = 0; e_bi[s] = 0; e_bl[s] = 0;
        end
        for (int i = 0; i < 4; i++) begin
            int op, m;
            int dest;
            int ln;
            if (!win_vld[i]) break;
            if (i > 0 && win_rdep[i]) break;
            op = int'(win_op[i*3 +: 3]);
            m  = int'(win_mask[i*4 +: 4]);
            dest = 0; ln = m;
            if (op == 6) begin
                if (!nused) begin nused = 1; e_nv = 1; e_ni = i; dest = 3; end
            end else if (op == 4) begin
                if (an == 0) begin dest = 1; ln = 15; end
            end else if (op == 5) begin
                ln = 8;
                if (an == 0 || (an == 1 && pair_fits(am, 8))) dest = 1;
            end else if (op == 0) begin
                if (bn == 0 || (bn == 1 && pair_fits(bm, m))) dest = 2;
                else if (an == 0 || (an == 1 && pair_fits(am, m))) dest = 1;
            end else begin
                if (bn == 0 || (bn == 1 && pair_fits(bm, m))) dest = 2;
            end
            if (dest == 0) break;
            if (dest == 1) begin
                e_av[an] = 1; e_ai[an] = i; e_al[an] = ln;
                am = am | ln;
                an = (op == 4) ? 2 : an + 1;
            end else if (dest == 2) begin
                e_bv[bn] = 1; e_bi[bn] = i; e_bl[bn] = ln;
                bm = bm | ln;
                bn = bn + 1;
            end
            e_cnt++;
        end
    endtask

    task automatic clr_win();
        win_vld = '0; win_op = '0; win_mask = '0; win_rdep = '0;
    endtask

    task automatic put(int i, int op, int m, bit rd);
        win_vld[i] = 1'b1;
        win_op[i*3 +: 3] = 3'(op);
        win_mask[i*4 +: 4] = 4'(m);
        win_rdep[i] = rd;
    endtask

    // Called at a falling edge with the window already driven.
    task automatic step(string tag, int hand_cnt);
        model();
        #1;
        chk(tag, "take_vld", int'(take_vld), int'(win_vld[0]));
        chk(tag, "take_cnt", int'(take_cnt), e_cnt);
        if (hand_cnt >= 0) chk(tag, "take_cnt_hand", int'(take_cnt), hand_cnt);
        @(posedge clk);
        #1;
        chk(tag, "iss_vld", int'(iss_vld), int'(win_vld[0]));
        chk(tag, "iss_cnt", int'(iss_cnt), e_cnt);
        for (int s = 0; s < 2; s++) begin
            chk(tag, "ua_vld", int'(ua_vld[s]), e_av[s]);
            chk(tag, "ub_vld", int'(ub_vld[s]), e_bv[s]);
            if (e_av[s] != 0) begin
                chk(tag, "ua_idx", int'(ua_idx[s*2 +: 2]), e_ai[s]);
                chk(tag, "ua_lanes", int'(ua_lanes[s*4 +: 4]), e_al[s]);
            end
            if (e_bv[s] != 0) begin
                chk(tag, "ub_idx", int'(ub_idx[s*2 +: 2]), e_bi[s]);
                chk(tag, "ub_lanes", int'(ub_lanes[s*4 +: 4]), e_bl[s]);
            end
        end
        chk(tag, "nrm_vld", int'(nrm_vld), e_nv);
        if (e_nv != 0) chk(tag, "nrm_idx", int'(nrm_idx), e_ni);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R2 watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int masks [10] = '{1, 2, 4, 8, 3, 12, 7, 15, 6, 5};
        put(0, 0, 15, 0);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds all issue outputs low
        chk("R1", "iss_vld", int'(iss_vld), 0);
        chk("R1", "ua_vld", int'(ua_vld), 0);
        chk("R1", "ub_vld", int'(ub_vld), 0);
        chk("R1", "nrm_vld", int'(nrm_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: ADD full on B, second ADD cannot split, later MUL held back
        clr_win(); put(0, 1, 15, 0); put(1, 1, 1, 0); put(2, 0, 15, 0);
        step("R3", 1);
        // R5: MULs fill B as 2+2, third MUL to A, ADD blocked
        clr_win(); put(0, 0, 3, 0); put(1, 0, 12, 0); put(2, 0, 15, 0); put(3, 1, 1, 0);
        step("R5", 3);
        // R10: same pattern checks slot order via the model
        step("R10", 3);
        // R7: texture locks A, MUL to B, ADD blocked
        clr_win(); put(0, 4, 0, 0); put(1, 0, 15, 0); put(2, 1, 1, 0); put(3, 0, 1, 0);
        step("R7", 2);
        // R7: texture behind an A-resident MUL cannot issue
        clr_win(); put(0, 0, 15, 0); put(1, 0, 15, 0); put(2, 4, 0, 0);
        step("R7", 2);
        // R8: CPLX joins A as the w lane of a 3+1 split
        clr_win(); put(0, 1, 15, 0); put(1, 0, 7, 0); put(2, 5, 1, 0); put(3, 6, 0, 0);
        step("R8", 4);
        // R8: CPLX behind a 2+2 candidate on A does not fit
        clr_win(); put(0, 1, 15, 0); put(1, 0, 12, 0); put(2, 5, 1, 0);
        step("R8", 2);
        // R4: entry 0 dependency ignored, entry 2 dependency stops
        clr_win(); put(0, 0, 1, 1); put(1, 1, 12, 0); put(2, 0, 15, 1); put(3, 1, 1, 0);
        step("R4", 2);
        clr_win(); put(0, 0, 1, 1); put(1, 1, 12, 0); put(2, 0, 15, 0); put(3, 1, 1, 0);
        step("R4", 3);
        // R9: second normalize ends the group
        clr_win(); put(0, 6, 0, 0); put(1, 6, 0, 0); put(2, 0, 15, 0);
        step("R9", 1);
        // R6: 3+1 pair, third blocked; overlapping 2-lane masks rejected
        clr_win(); put(0, 1, 7, 0); put(1, 1, 8, 0); put(2, 1, 1, 0);
        step("R6", 2);
        clr_win(); put(0, 1, 3, 0); put(1, 1, 6, 0);
        step("R6", 1);
        // R2: empty window
        clr_win();
        step("R2", 0);

        for (int n = 0; n < 3000; n++) begin
            int len;
            clr_win();
            len = $urandom_range(0, 4);
            for (int i = 0; i < len; i++)
                put(i, $urandom_range(0, 6), masks[$urandom_range(0, 9)],
                    ($urandom_range(0, 5) == 0));
            step("R2", -1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule